// File: doc/BRIEF.md
# SDRAM Single-Port Controller

This block connects a simple request stream to one four-bank SDRAM device with a 16-bit data path. A requester presents a read or write with a linear word address and, for writes, one data word. The controller opens the addressed row, issues one column access with auto-precharge, and returns read data on a response port after the programmed CAS latency. Each access is closed-page: every request opens its own row and closes it again on its own. This keeps the row timing limits simple to meet.

The memory side is driven by registered chip-select, row-strobe, column-strobe and write-enable pins, a 2-bit bank select, a 12-bit address bus, two byte-mask lines and a split data bus: an output word with its enable and an input word, for joining at the pad. Periodic auto-refresh is built in. When a refresh falls due, the controller waits out the row-active limit, closes all banks, then issues the refresh. During that time it stops taking requests. All limits are derived from nanosecond parameters at a 7.5 ns clock, except the precharge period, which is given in cycles.

The request port uses a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold its request stable. `req_ready` depends only on internal state and never on `req_valid`. The read response has no back-pressure: `rsp_valid` is high for one cycle, and the consumer must take the word in that cycle.

Top module: `sdc_ctrl`

## Requirements
- R1: During reset and until the first request, the command pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111). `sd_dq_oe` and `rsp_valid` are low, and `sd_dqm` is 11. `req_ready` is high in the first cycle after reset is released.
- R2: The command is coded as {cs_n,ras_n,cas_n,we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, and 1111 when idle. `req_addr` splits into bank [22:21], row [20:9] and column [8:0]. Each accepted request, in acceptance order, produces an activate carrying its bank on `sd_ba` and its row on `sd_addr`. It then produces a read or write (matching `req_write`) to the same bank, with `sd_addr[8:0]` = column, `sd_addr[10]` = 1 (auto-precharge), and `sd_addr[9]` and `sd_addr[11]` = 0.
- R3: A read or write appears exactly 3 cycles after the activate of its request.
- R4: An activate appears at least 9 cycles after the previous activate or refresh. A refresh appears at least 9 cycles after the previous activate.
- R5: A precharge appears at least 6 cycles after the previous activate.
- R6: Each refresh is preceded by a precharge with `sd_addr[10]` = 1, issued at least 3 cycles before it. The first refresh comes no later than 2083+30 cycles after reset. Consecutive refreshes are spaced between 2083-30 and 2083+30 cycles.
- R7: Between the all-bank precharge and its refresh, no activate is issued and `req_ready` stays low. A pending refresh wins over new requests, so R6 spacing holds under a continuous request stream.
- R8: `sd_dq_oe` is high only in the cycle showing a write command. In that cycle `sd_dq_out` equals the request's write data.
- R9: `rsp_valid` is high for one cycle, 4 cycles after the cycle showing a read command (CAS latency 3 plus one capture register). `rsp_rdata` then equals the word that was on `sd_dq_in` in the cycle 3 cycles after the read command.
- R10: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after a request is accepted.
- R11: `sd_dqm` is 00 in a write-command cycle and in every cycle from a read command through 3 cycles after it; it is 11 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Linear word address {bank,row,column} |
| req_wdata | input | 16 | Write data word |
| rsp_valid | output | 1 | Read data valid, single cycle, no back-pressure |
| rsp_rdata | output | 16 | Read data word |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Memory row strobe, active low |
| sd_cas_n | output | 1 | Memory column strobe, active low |
| sd_we_n | output | 1 | Memory write enable, active low |
| sd_ba | output | 2 | Memory bank select |
| sd_addr | output | 12 | Memory row/column address, bit 10 precharge option |
| sd_dqm | output | 2 | Memory byte masks, high masks |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out at the pad |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
The assertions assume that the device returns read data in time to be sampled 3 cycles after the read command. They also assume that the requester holds `req_valid` and its fields steady while `req_ready` is low, and that it always takes a response word the cycle it appears. The bench honours these assumptions. Its memory model drives `sd_dq_in` half a cycle before the capturing edge. It changes the request pins only on falling edges and only after an acceptance, and it records every returned word in the cycle where `rsp_valid` is seen. A read is only ever issued to an address that was written earlier, so every expected word is defined.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTW,
    ST_PREW,
    ST_RPW
  } sdc_state_e;

  // Round a picosecond limit up to whole clock cycles.
  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (load)           left_q <= val;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign done = (left_q == '0);

endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int INTERVAL = 2083
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      if (cnt_q == CW'(INTERVAL - 1)) begin
        cnt_q <= '0;
        due_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (ack) due_q <= 1'b0;
      end
    end
  end

  assign due = due_q;

endmodule

// File: rtl/sdc_rdpipe.sv
module sdc_rdpipe #(
  parameter int CL = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic [CL:0]   pipe_q;
  logic          vld_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pipe_q <= {pipe_q[CL-1:0], issue};
      vld_q  <= pipe_q[CL];
      if (pipe_q[CL]) data_q <= dq_in;
    end
  end

  assign busy      = |pipe_q[CL-1:0];
  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int CLK_PS    = 7500,
  parameter int T_RCD_PS  = 20000,
  parameter int T_RAS_PS  = 45000,
  parameter int T_RC_PS   = 67500,
  parameter int T_REFI_PS = 15625000,
  parameter int RP_CYC    = 3,
  parameter int CAS_LAT   = 3,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DW        = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DW-1:0]                   req_wdata,
  output logic                            rsp_valid,
  output logic [DW-1:0]                   rsp_rdata,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DW/8-1:0]                 sd_dqm,
  output logic [DW-1:0]                   sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DW-1:0]                   sd_dq_in
);

  localparam int RCD_C  = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int RAS_C  = ps_to_cyc(T_RAS_PS, CLK_PS);
  localparam int RC_C   = ps_to_cyc(T_RC_PS, CLK_PS);
  localparam int REFI_C = T_REFI_PS / CLK_PS;
  localparam int TM1    = (RC_C > RAS_C) ? RC_C : RAS_C;
  localparam int TM2    = (TM1 > RCD_C) ? TM1 : RCD_C;
  localparam int TMAX   = (TM2 > RP_CYC) ? TM2 : RP_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int NT     = 4;
  localparam int TI_RCD = 0;
  localparam int TI_RAS = 1;
  localparam int TI_RC  = 2;
  localparam int TI_RP  = 3;
  localparam int AP_BIT = 10;

  sdc_state_e state_q, state_n;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [DW-1:0]     data_q;

  sd_cmd_e           cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_q, ba_n;
  logic [ROW_W-1:0]  addr_q, addr_n;
  logic              oe_q, oe_n;
  logic [DW-1:0]     dout_q;
  logic [DW/8-1:0]   dqm_q, dqm_n;

  logic [NT-1:0]         t_load, t_done;
  logic [NT-1:0][TW-1:0] t_val;
  logic ref_due, ref_ack, rd_issue, rd_busy, accept;

  assign t_val[TI_RCD] = TW'(RCD_C - 1);
  assign t_val[TI_RAS] = TW'(RAS_C - 1);
  assign t_val[TI_RC]  = TW'(RC_C - 1);
  assign t_val[TI_RP]  = TW'(RP_CYC - 1);

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    sdc_gap_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load[g]), .val(t_val[g]), .done(t_done[g])
    );
  end

  sdc_refresh_timer #(.INTERVAL(REFI_C)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
  );

  sdc_rdpipe #(.CL(CAS_LAT), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
    .busy(rd_busy), .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE) && t_done[TI_RC] && !ref_due;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_n  = state_q;
    cmd_n    = CMD_DESEL;
    ba_n     = '0;
    addr_n   = '0;
    oe_n     = 1'b0;
    t_load   = '0;
    ref_ack  = 1'b0;
    rd_issue = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_due) begin
          state_n = ST_PREW;
        end else if (accept) begin
          cmd_n          = CMD_ACT;
          ba_n           = req_addr[COL_W+ROW_W +: BANK_W];
          addr_n         = req_addr[COL_W +: ROW_W];
          t_load[TI_RCD] = 1'b1;
          t_load[TI_RAS] = 1'b1;
          t_load[TI_RC]  = 1'b1;
          state_n        = ST_ACTW;
        end
      end
      ST_ACTW: begin
        if (t_done[TI_RCD]) begin
          cmd_n          = wr_q ? CMD_WRITE : CMD_READ;
          ba_n           = bank_q;
          addr_n         = ROW_W'(col_q);
          addr_n[AP_BIT] = 1'b1;
          oe_n           = wr_q;
          rd_issue       = !wr_q;
          state_n        = ST_IDLE;
        end
      end
      ST_PREW: begin
        if (t_done[TI_RAS]) begin
          cmd_n          = CMD_PRE;
          addr_n[AP_BIT] = 1'b1;
          t_load[TI_RP]  = 1'b1;
          state_n        = ST_RPW;
        end
      end
      default: begin
        if (t_done[TI_RP] && t_done[TI_RC]) begin
          cmd_n         = CMD_REF;
          t_load[TI_RC] = 1'b1;
          ref_ack       = 1'b1;
          state_n       = ST_IDLE;
        end
      end
    endcase
    dqm_n = (cmd_n == CMD_READ || cmd_n == CMD_WRITE || rd_busy) ? '0 : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      col_q   <= '0;
      data_q  <= '0;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      dout_q  <= '0;
      dqm_q   <= '1;
    end else begin
      state_q <= state_n;
      if (accept) begin
        wr_q   <= req_write;
        bank_q <= req_addr[COL_W+ROW_W +: BANK_W];
        col_q  <= req_addr[COL_W-1:0];
        data_q <= req_wdata;
      end
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      oe_q   <= oe_n;
      dout_q <= oe_n ? data_q : '0;
      dqm_q  <= dqm_n;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dout_q;
  assign sd_dq_oe  = oe_q;

endmodule

// File: rtl/sdc_ctrl_chk.sv
module sdc_ctrl_chk #(
  parameter int RCD = 3,
  parameter int RAS = 6,
  parameter int RC  = 9,
  parameter int RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic rsp_valid,
  input logic req_ready
);

  logic [3:0] c;
  logic is_act, is_rw, is_wr, is_pre, is_ref;
  logic [7:0] since_act, since_actref, since_pre;

  assign c      = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (c == 4'b0011);
  assign is_wr  = (c == 4'b0100);
  assign is_rw  = (c == 4'b0101) || is_wr;
  assign is_pre = (c == 4'b0010);
  assign is_ref = (c == 4'b0001);

  function automatic logic [7:0] sat_inc(input logic [7:0] x);
    return (x == 8'hff) ? x : x + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act    <= 8'hff;
      since_actref <= 8'hff;
      since_pre    <= 8'hff;
    end else begin
      since_act    <= is_act ? 8'd1 : sat_inc(since_act);
      since_actref <= (is_act || is_ref) ? 8'd1 : sat_inc(since_actref);
      since_pre    <= is_pre ? 8'd1 : sat_inc(since_pre);
    end
  end

  AST_RCD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (32'(since_act) == RCD)); // R3
  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (32'(since_actref) >= RC)); // R4
  AST_REF_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (32'(since_act) >= RC)); // R4
  AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (32'(since_act) >= RAS)); // R5
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (32'(since_pre) >= RP)); // R6
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> is_wr); // R8
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !req_ready); // R10

endmodule

bind sdc_ctrl sdc_ctrl_chk #(
  .RCD(RCD_C), .RAS(RAS_C), .RC(RC_C), .RP(RP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .dq_oe(sd_dq_oe),
  .rsp_valid(rsp_valid), .req_ready(req_ready)
);

// File: tb/sim_sdc_ctrl.sv
module sim_sdc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CL    = 3;
  localparam int RCD   = 3;
  localparam int RAS   = 6;
  localparam int RC    = 9;
  localparam int RP    = 3;
  localparam int REFI  = 2083;
  localparam int SLACK = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [1:0]  dqm;
  logic [15:0] dq_out, dq_in = 16'hdead;
  logic        dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .sd_dqm(dqm), .sd_dq_out(dq_out),
    .sd_dq_oe(dq_oe), .sd_dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0t", req, act, exp, $time);
    end
  endtask

  // reference data and accepted-request queues
  logic [15:0] ref_mem [int];
  logic [15:0] dmem [int];
  logic [22:0] q_addr [$];
  logic        q_wr [$];
  logic [15:0] q_data [$];
  logic [11:0] open_row [4];

  // monitor + memory model
  int cyc = 0, last_act = -1000, last_actref = -1000, last_pre = -1000, last_ref = 0;
  int ref_cnt = 0, rd_due = -1, dqm_until = -1, rd_cnt = 0, rd_key = 0;
  bit in_ref = 0;
  logic [22:0] cur_addr;
  logic        cur_wr;
  logic [15:0] cur_data, rd_exp;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] c;
      cyc++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) dq_in = dmem.exists(rd_key) ? dmem[rd_key] : 16'hbad0;
      end
      case (c)
        4'b0011: begin
          chk(!in_ref, "R7 act during refresh", 1, 0);
          chk(cyc - last_actref >= RC, "R4 act spacing", cyc - last_actref, RC);
          chk(!req_ready, "R10 ready after accept", req_ready, 0);
          if (q_addr.size() == 0) chk(0, "R2 act without request", 0, 1);
          else begin
            cur_addr = q_addr.pop_front(); cur_wr = q_wr.pop_front(); cur_data = q_data.pop_front();
            chk(ba == cur_addr[22:21], "R2 act bank", ba, cur_addr[22:21]);
            chk(addr == cur_addr[20:9], "R2 act row", addr, cur_addr[20:9]);
          end
          open_row[ba] = addr;
          last_act = cyc; last_actref = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(cyc - last_act == RCD, "R3 act to column", cyc - last_act, RCD);
          chk(ba == cur_addr[22:21], "R2 column bank", ba, cur_addr[22:21]);
          chk({addr[11:9], addr[8:0]} == {3'b010, cur_addr[8:0]}, "R2 column addr", addr, {3'b010, cur_addr[8:0]});
          chk((c == 4'b0100) == cur_wr, "R2 command kind", c, cur_wr);
          rd_key = {ba, open_row[ba], addr[8:0]};
          if (c == 4'b0100) begin
            chk(dq_oe && dq_out == cur_data, "R8 write data", {dq_oe, dq_out}, {1'b1, cur_data});
            dmem[rd_key] = dq_out;
          end else begin
            rd_cnt = CL; rd_due = cyc + CL + 1; dqm_until = cyc + CL;
            rd_exp = ref_mem[int'(cur_addr)];
          end
        end
        4'b0010: begin
          chk(addr[10], "R6 precharge all", addr[10], 1);
          chk(cyc - last_act >= RAS, "R5 active to precharge", cyc - last_act, RAS);
          in_ref = 1; last_pre = cyc;
        end
        4'b0001: begin
          chk(in_ref, "R6 refresh without precharge", in_ref, 1);
          chk(cyc - last_pre >= RP, "R6 precharge to refresh", cyc - last_pre, RP);
          chk(cyc - last_act >= RC, "R4 act to refresh", cyc - last_act, RC);
          chk(cyc - last_ref <= REFI + SLACK, "R6 refresh late", cyc - last_ref, REFI);
          if (ref_cnt > 0) chk(cyc - last_ref >= REFI - SLACK, "R6 refresh early", cyc - last_ref, REFI);
          ref_cnt++; last_ref = cyc; last_actref = cyc; in_ref = 0;
        end
        4'b1111: ;
        default: chk(0, "R2 unexpected command", c, 4'hf);
      endcase
      if (in_ref && c != 4'b0010) chk(!req_ready, "R7 ready during refresh", req_ready, 0);
      if (c != 4'b0100 && dq_oe) chk(0, "R8 oe outside write", dq_oe, 0);
      begin
        logic [1:0] dqm_exp;
        dqm_exp = (c == 4'b0100 || c == 4'b0101 || cyc <= dqm_until) ? 2'b00 : 2'b11;
        if (dqm != dqm_exp) chk(0, "R11 dqm", dqm, dqm_exp);
      end
      if (rsp_valid) begin
        chk(cyc == rd_due, "R9 read latency", cyc, rd_due);
        chk(rsp_rdata == rd_exp, "R9 read data", rsp_rdata, rd_exp);
      end else if (cyc == rd_due) chk(0, "R9 missing response", 0, 1);
    end
  end

  task automatic do_op(input bit wr, input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    q_addr.push_back(a); q_wr.push_back(wr); q_data.push_back(d);
    if (wr) ref_mem[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready low after accept", req_ready, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'hf, "R1 reset command", {cs_n, ras_n, cas_n, we_n}, 4'hf);
    chk(!dq_oe && dqm == 2'b11 && !rsp_valid, "R1 reset outputs", {dq_oe, dqm, rsp_valid}, 4'b0110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'hf, "R1 idle deselect", {cs_n, ras_n, cas_n, we_n}, 4'hf);
  endtask

  task automatic t_patterns();
    logic [22:0] a [4];
    logic [15:0] d [4];
    a[0] = 23'h7fffff; d[0] = 16'hffff;
    a[1] = 23'h000000; d[1] = 16'h0000;
    a[2] = {2'd1, 12'h800, 9'h100}; d[2] = 16'ha5a5;
    a[3] = {2'd2, 12'h001, 9'h000}; d[3] = 16'h5a5a;
    for (int i = 0; i < 4; i++) do_op(1, a[i], d[i]);
    for (int i = 0; i < 4; i++) do_op(0, a[i], 16'h0);
    for (int i = 0; i < 4; i++) do_op(0, a[3-i], 16'h0);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_stream(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [22:0] a;
      a = 23'((i * 7919 + seed) & 32'h7fffff);
      do_op(1, a, 16'((i * 16'h3c5) ^ 16'h5a5a ^ seed));
    end
    for (int i = 0; i < n; i++) do_op(0, 23'((i * 7919 + seed) & 32'h7fffff), 16'h0);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_refresh_idle();
    int waited = 0;
    while (ref_cnt < 4 && waited < 9000) begin
      @(negedge clk); waited++;
    end
    chk(ref_cnt >= 4, "R6 refresh count", ref_cnt, 4);
    chk(q_addr.size() == 0, "R2 all requests issued", q_addr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_stream(150, 13);
    t_stream(120, 4242);
    t_refresh_idle();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule